// File: doc/BRIEF.md
# Polled Multichannel Spectroscopy Readout Controller

This controller services an array of detector channels that share one analog shaping chain. It selects one channel at a time by driving a channel index and closing only that channel's read switch. It then gives the shared chain a bounded number of clock cycles to report an event. An event is reported by a ready flag, followed by a converted peak code with a valid strobe. When an event arrives, the controller increments the matching energy bin in an external histogram memory. Every visit, hit or miss, ends with a single-cycle acknowledge that rearms the shared peak holder, and the controller then moves to the next channel in strict rotation.

Each channel has its own spectrum. The histogram address is the channel index in the upper bits and the energy code in the lower bits. Counters saturate instead of wrapping. A clear command, accepted while the controller is idle, walks the whole histogram and writes zero to every bin. Polling starts on a start request and stops at the next visit boundary after a stop request.

The external memory has a one-cycle read latency: data requested in one cycle is presented on the read-data input in the next cycle.

Top module: `spec_poll_ctrl`

## Requirements
- R1: After reset, the channel index is 0, all switch enables are 0, and acknowledge, frame-done, clear-busy, histogram read and histogram write are all 0.
- R2: While a channel is being visited, exactly switch enable bit `ch_addr_o` is 1 and all other bits are 0. While idle, while clearing, and in the cycle after acknowledge, all switch enables are 0.
- R3: A hit is ready seen during the window, followed by a valid strobe, both before the window expires. On a hit, the controller reads address {channel, code} with the channel in the high bits. In the next cycle it writes that address with the read value plus one, and acknowledge follows.
- R4: Acknowledge is high for exactly one cycle at the end of every visit, whether the visit was a hit or a miss.
- R5: If no hit occurs, the selection lasts exactly WAIT_CYC cycles before acknowledge is raised, and no histogram write occurs.
- R6: A bin holding the all-ones value stays at all-ones when incremented, so a written count is never zero.
- R7: Channels are visited in the order 0, 1, …, NUM_CH-1, 0. Frame-done is high for one cycle, in the cycle after the acknowledge of channel NUM_CH-1, and in the next cycle the index reads 0.
- R8: In the cycle after acknowledge, the channel index still holds the acknowledged channel and all switches are open. The index advances by one only after that cycle.
- R9: A clear request while idle holds clear-busy high for exactly 2^(CH_W+CODE_W) cycles. In those cycles it writes zero to every address, resets the channel index to 0, and ignores start.
- R10: A stop request lets the current visit finish with its acknowledge, then leaves all switches open with the index on the next channel. A later start resumes the visits from that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin polling (taken while idle) |
| stop_i | input | 1 | Halt polling at the next visit boundary |
| clear_i | input | 1 | Zero the histogram (taken while idle) |
| ready_i | input | 1 | Event flag from the shared comparator |
| adc_valid_i | input | 1 | Converted code is valid |
| adc_code_i | input | CODE_W | Converted peak energy code |
| ch_addr_o | output | CH_W | Selected channel index |
| sw_en_o | output | NUM_CH | One-hot read switch enables |
| ack_o | output | 1 | One-cycle rearm pulse closing each visit |
| frame_done_o | output | 1 | Pulse when the rotation wraps to channel 0 |
| clr_busy_o | output | 1 | Histogram clear in progress |
| hist_addr_o | output | CH_W+CODE_W | Histogram address |
| hist_rd_o | output | 1 | Histogram read strobe |
| hist_rd_data_i | input | BIN_W | Histogram read data, one cycle after the read |
| hist_wr_o | output | 1 | Histogram write strobe |
| hist_wr_data_o | output | BIN_W | Histogram write data |

## Verification
The bench measures the length of each miss. A controller with an off-by-one window would acknowledge one cycle early or late. It also watches the cycle after every acknowledge, where an early address change would let two switches overlap in time. Repeated hits on the last address, which is also the highest-numbered channel's top bin, would wrap to a small count if saturation were missing or the address were built in the wrong order. Stop and clear are checked for the right resume channel, for writing every bin, and for ignoring a start during the clear.

// File: rtl/spec_pkg.sv
package spec_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CLEAR = 3'd1,
    ST_WAIT  = 3'd2,
    ST_RD    = 3'd3,
    ST_WR    = 3'd4,
    ST_ACK   = 3'd5,
    ST_ADV   = 3'd6
  } poll_st_e;

endpackage

// File: rtl/spec_chan_decode.sv
module spec_chan_decode #(
  parameter int NUM_CH = 32,
  parameter int CH_W   = 5
) (
  input  logic              en_i,
  input  logic [CH_W-1:0]   ch_i,
  output logic [NUM_CH-1:0] onehot_o
);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_sw
    assign onehot_o[g] = en_i && (ch_i == CH_W'(g));
  end

endmodule

// File: rtl/spec_win_timer.sv
module spec_win_timer #(
  parameter int WAIT_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic expire_o
);

  localparam int TW = $clog2(WAIT_CYC + 1);
  localparam logic [TW-1:0] LAST = TW'(WAIT_CYC - 1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en   = run_i || (cnt_q != '0);
  assign expire_o = run_i && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)         cnt_d = '0;
    else if (!expire_o) cnt_d = cnt_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/spec_bin_update.sv
module spec_bin_update #(
  parameter int CH_W   = 5,
  parameter int CODE_W = 6,
  parameter int BIN_W  = 16
) (
  input  logic [CH_W-1:0]        ch_i,
  input  logic [CODE_W-1:0]      code_i,
  input  logic [BIN_W-1:0]       cur_i,
  output logic [CH_W+CODE_W-1:0] addr_o,
  output logic [BIN_W-1:0]       next_o
);

  localparam logic [BIN_W-1:0] FULL = {BIN_W{1'b1}};

  assign addr_o = {ch_i, code_i};

  always_comb begin
    if (cur_i == FULL) next_o = FULL;
    else               next_o = cur_i + BIN_W'(1);
  end

endmodule

// File: rtl/spec_clear_walker.sv
module spec_clear_walker #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);

  logic [ADDR_W-1:0] addr_q, addr_d;

  assign addr_o = addr_q;
  assign last_o = run_i && (addr_q == {ADDR_W{1'b1}});

  always_comb begin
    addr_d = addr_q;
    if (!run_i)      addr_d = '0;
    else if (last_o) addr_d = '0;
    else             addr_d = addr_q + ADDR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

endmodule

// File: rtl/spec_poll_ctrl.sv
module spec_poll_ctrl
  import spec_pkg::*;
#(
  parameter  int NUM_CH   = 32,
  parameter  int CODE_W   = 6,
  parameter  int BIN_W    = 16,
  parameter  int WAIT_CYC = 1000,
  localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W   = CH_W + CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              clear_i,
  input  logic              ready_i,
  input  logic              adc_valid_i,
  input  logic [CODE_W-1:0] adc_code_i,
  output logic [CH_W-1:0]   ch_addr_o,
  output logic [NUM_CH-1:0] sw_en_o,
  output logic              ack_o,
  output logic              frame_done_o,
  output logic              clr_busy_o,
  output logic [ADDR_W-1:0] hist_addr_o,
  output logic              hist_rd_o,
  input  logic [BIN_W-1:0]  hist_rd_data_i,
  output logic              hist_wr_o,
  output logic [BIN_W-1:0]  hist_wr_data_o
);

  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  poll_st_e          st_q, st_d;
  logic [CH_W-1:0]   ch_q, ch_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              rdy_q, rdy_d;
  logic              stop_q, stop_d;

  logic              in_wait, in_visit, win_expire;
  logic              clr_run, clr_last;
  logic [ADDR_W-1:0] clr_addr, bin_addr;
  logic [BIN_W-1:0]  bin_next;
  logic              hit;

  assign in_wait  = (st_q == ST_WAIT);
  assign in_visit = (st_q == ST_WAIT) || (st_q == ST_RD) ||
                    (st_q == ST_WR)   || (st_q == ST_ACK);
  assign clr_run  = (st_q == ST_CLEAR);
  assign hit      = in_wait && (rdy_q || ready_i) && adc_valid_i;

  spec_chan_decode #(.NUM_CH(NUM_CH), .CH_W(CH_W)) i_decode (
    .en_i     (in_visit),
    .ch_i     (ch_q),
    .onehot_o (sw_en_o)
  );

  spec_win_timer #(.WAIT_CYC(WAIT_CYC)) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (in_wait),
    .expire_o (win_expire)
  );

  spec_bin_update #(.CH_W(CH_W), .CODE_W(CODE_W), .BIN_W(BIN_W)) i_bin (
    .ch_i   (ch_q),
    .code_i (code_q),
    .cur_i  (hist_rd_data_i),
    .addr_o (bin_addr),
    .next_o (bin_next)
  );

  spec_clear_walker #(.ADDR_W(ADDR_W)) i_walk (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (clr_run),
    .addr_o (clr_addr),
    .last_o (clr_last)
  );

  // next-state logic
  always_comb begin
    st_d   = st_q;
    ch_d   = ch_q;
    code_d = code_q;
    rdy_d  = 1'b0;
    stop_d = stop_q;
    if (in_visit && stop_i) stop_d = 1'b1;
    unique case (st_q)
      ST_IDLE: begin
        stop_d = 1'b0;
        if (clear_i)              st_d = ST_CLEAR;
        else if (start_i && !stop_i) st_d = ST_WAIT;
      end
      ST_CLEAR: begin
        ch_d = '0;
        if (clr_last) st_d = ST_IDLE;
      end
      ST_WAIT: begin
        rdy_d = rdy_q || ready_i;
        if (hit) begin
          code_d = adc_code_i;
          st_d   = ST_RD;
        end else if (win_expire) begin
          st_d = ST_ACK;
        end
      end
      ST_RD:   st_d = ST_WR;
      ST_WR:   st_d = ST_ACK;
      ST_ACK:  st_d = ST_ADV;
      ST_ADV: begin
        ch_d = (ch_q == LAST_CH) ? '0 : ch_q + CH_W'(1);
        if (stop_q || stop_i) begin
          st_d   = ST_IDLE;
          stop_d = 1'b0;
        end else begin
          st_d = ST_WAIT;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ch_q   <= '0;
      code_q <= '0;
      rdy_q  <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ch_q   <= ch_d;
      rdy_q  <= rdy_d;
      stop_q <= stop_d;
      if (hit) code_q <= code_d;
    end
  end

  // outputs
  assign ch_addr_o      = ch_q;
  assign ack_o          = (st_q == ST_ACK);
  assign frame_done_o   = (st_q == ST_ADV) && (ch_q == LAST_CH);
  assign clr_busy_o     = clr_run;
  assign hist_rd_o      = (st_q == ST_RD);
  assign hist_wr_o      = (st_q == ST_WR) || clr_run;
  assign hist_addr_o    = clr_run ? clr_addr : bin_addr;
  assign hist_wr_data_o = clr_run ? '0 : bin_next;

endmodule

// File: rtl/spec_poll_ctrl_chk.sv
module spec_poll_ctrl_chk #(
  parameter int NUM_CH = 32,
  parameter int CH_W   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CH_W-1:0]   ch_addr_o,
  input logic [NUM_CH-1:0] sw_en_o,
  input logic              ack_o,
  input logic              frame_done_o,
  input logic              clr_busy_o,
  input logic              hist_rd_o,
  input logic              hist_wr_o,
  input logic [15:0]       wr_nz
);

  p_sw_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sw_en_o));

  p_clear_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_busy_o |-> (sw_en_o == '0));

  p_wr_follows_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_wr_o && !clr_busy_o) |-> $past(hist_rd_o));

  p_ack_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> !ack_o);

  p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_wr_o && !clr_busy_o) |-> (wr_nz != 16'd0));

  p_frame_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |=> (ch_addr_o == '0));

  p_break_before_make_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> ((sw_en_o == '0) && $stable(ch_addr_o)));

endmodule

bind spec_poll_ctrl spec_poll_ctrl_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ch_addr_o    (ch_addr_o),
  .sw_en_o      (sw_en_o),
  .ack_o        (ack_o),
  .frame_done_o (frame_done_o),
  .clr_busy_o   (clr_busy_o),
  .hist_rd_o    (hist_rd_o),
  .hist_wr_o    (hist_wr_o),
  .wr_nz        (16'(hist_wr_data_o))
);

// File: tb/test_spec_poll_ctrl.sv
`timescale 1ns/1ps
module test_spec_poll_ctrl;

  localparam int NCH = 4;
  localparam int CW  = 3;
  localparam int BW  = 3;
  localparam int WC  = 16;
  localparam int CHW = 2;
  localparam int AW  = CHW + CW;
  localparam int DEPTH = 1 << AW;
  localparam int FULL  = (1 << BW) - 1;

  logic clk, rst_n;
  logic start_i, stop_i, clear_i, ready_i, adc_valid_i;
  logic [CW-1:0]  adc_code_i;
  logic [CHW-1:0] ch_addr_o;
  logic [NCH-1:0] sw_en_o;
  logic ack_o, frame_done_o, clr_busy_o, hist_rd_o, hist_wr_o;
  logic [AW-1:0] hist_addr_o;
  logic [BW-1:0] hist_rd_data_i, hist_wr_data_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [BW-1:0] mem [DEPTH];
  int  exp_bin [DEPTH];
  bit  hit_pend [NCH];
  logic [CW-1:0] hit_code [NCH];
  bit  preload_en = 0;
  logic [BW-1:0] preload_val = '0;
  int  fd_count = 0;

  spec_poll_ctrl #(.NUM_CH(NCH), .CODE_W(CW), .BIN_W(BW), .WAIT_CYC(WC)) i_spec_poll_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i), .clear_i(clear_i),
    .ready_i(ready_i), .adc_valid_i(adc_valid_i), .adc_code_i(adc_code_i),
    .ch_addr_o(ch_addr_o), .sw_en_o(sw_en_o), .ack_o(ack_o), .frame_done_o(frame_done_o),
    .clr_busy_o(clr_busy_o), .hist_addr_o(hist_addr_o), .hist_rd_o(hist_rd_o),
    .hist_rd_data_i(hist_rd_data_i), .hist_wr_o(hist_wr_o), .hist_wr_data_o(hist_wr_data_o)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  // histogram memory model, one-cycle read latency
  always @(posedge clk) begin
    if (preload_en) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= preload_val;
    end else begin
      if (hist_rd_o) hist_rd_data_i <= mem[hist_addr_o];
      if (hist_wr_o) mem[hist_addr_o] <= hist_wr_data_o;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int sat_add(input int v);
    return (v >= FULL) ? FULL : v + 1;
  endfunction

  // analog chain model: ready on 3rd selected cycle, code valid on 5th
  initial begin
    int sel_cnt = 0;
    ready_i = 0; adc_valid_i = 0; adc_code_i = '0;
    forever begin
      @(negedge clk);
      if (sw_en_o != '0 && !ack_o) begin
        sel_cnt++;
        adc_valid_i = 0;
        if (hit_pend[ch_addr_o]) begin
          if (sel_cnt == 3) ready_i = 1;
          if (sel_cnt == 5) begin
            adc_valid_i = 1;
            adc_code_i  = hit_code[ch_addr_o];
          end
          if (sel_cnt == 6) hit_pend[ch_addr_o] = 0;
        end
      end else begin
        sel_cnt = 0; ready_i = 0; adc_valid_i = 0;
      end
    end
  end

  // protocol monitor
  initial begin
    logic [NCH-1:0] prev_sw = '0;
    bit ack_prev = 0, nxt_pend = 0, visit_hit = 0, fd_prev = 0;
    int visit_len = 0, ack_ch = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        prev_sw = '0; ack_prev = 0; nxt_pend = 0; fd_prev = 0;
      end else begin
        if (sw_en_o != '0)
          check(sw_en_o == (NCH'(1) << ch_addr_o), "R2 onehot", int'(sw_en_o), 1 << ch_addr_o);
        if (clr_busy_o) begin
          nxt_pend = 0;
          check(sw_en_o == '0, "R9 switches open in clear", int'(sw_en_o), 0);
        end
        if (ack_prev) begin
          check(!ack_o, "R4 ack width", int'(ack_o), 0);
          check(sw_en_o == '0, "R8 open after ack", int'(sw_en_o), 0);
          check(ch_addr_o == CHW'(ack_ch), "R8 index held", int'(ch_addr_o), ack_ch);
          nxt_pend = 1;
        end else if (nxt_pend && sw_en_o != '0) begin
          check(int'(ch_addr_o) == (ack_ch + 1) % NCH, "R7 rotation", int'(ch_addr_o), (ack_ch + 1) % NCH);
          nxt_pend = 0;
        end
        if (fd_prev)
          check(ch_addr_o == '0, "R7 wrap to 0", int'(ch_addr_o), 0);
        if (frame_done_o) begin
          fd_count++;
          check(ch_addr_o == CHW'(NCH - 1) && sw_en_o == '0, "R7 frame-done", int'(ch_addr_o), NCH - 1);
        end
        if (sw_en_o != '0 && prev_sw == '0) begin
          visit_len = 0;
          visit_hit = hit_pend[ch_addr_o];
        end
        if (sw_en_o != '0 && !ack_o) visit_len++;
        if (ack_o && !ack_prev) begin
          ack_ch = int'(ch_addr_o);
          if (!visit_hit) check(visit_len == WC, "R5 miss window", visit_len, WC);
          else            check(visit_len < WC, "R3 hit before expiry", visit_len, WC - 1);
        end
        if (hist_wr_o && !clr_busy_o && !visit_hit)
          check(0, "R5 write on miss", 1, 0);
        fd_prev  = frame_done_o;
        ack_prev = ack_o;
        prev_sw  = sw_en_o;
      end
    end
  end

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1;
    @(negedge clk); sig = 0;
  endtask

  task automatic stop_to_idle();
    @(negedge clk); stop_i = 1;
    @(negedge clk); stop_i = 0;
    while (!ack_o) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic compare_mem(input string req);
    for (int a = 0; a < DEPTH; a++)
      check(int'(mem[a]) == exp_bin[a], req, int'(mem[a]), exp_bin[a]);
  endtask

  task automatic t_reset();
    rst_n = 0; start_i = 0; stop_i = 0; clear_i = 0;
    for (int c = 0; c < NCH; c++) begin hit_pend[c] = 0; hit_code[c] = '0; end
    repeat (3) @(negedge clk);
    check(ch_addr_o == '0, "R1 index", int'(ch_addr_o), 0);
    check(sw_en_o == '0, "R1 switches", int'(sw_en_o), 0);
    check(!ack_o && !frame_done_o && !clr_busy_o, "R1 pulses", int'(ack_o), 0);
    check(!hist_rd_o && !hist_wr_o, "R1 memory strobes", int'(hist_wr_o), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_clear();
    int busy = 0;
    preload_val = 3'd5; preload_en = 1;
    @(negedge clk); preload_en = 0;
    clear_i = 1;
    @(negedge clk); clear_i = 0; start_i = 1;
    while (clr_busy_o) begin
      busy++;
      @(negedge clk);
      start_i = 0;
    end
    start_i = 0;
    check(busy == DEPTH, "R9 clear length", busy, DEPTH);
    repeat (5) @(negedge clk);
    check(sw_en_o == '0, "R9 start ignored during clear", int'(sw_en_o), 0);
    check(ch_addr_o == '0, "R9 index reset", int'(ch_addr_o), 0);
    for (int a = 0; a < DEPTH; a++) exp_bin[a] = 0;
    compare_mem("R9 bins zeroed");
  endtask

  task automatic t_hits();
    int fd0 = fd_count;
    hit_pend[0] = 1; hit_code[0] = 3'd2; exp_bin[{2'd0, 3'd2}] = sat_add(exp_bin[{2'd0, 3'd2}]);
    hit_pend[1] = 1; hit_code[1] = 3'd5; exp_bin[{2'd1, 3'd5}] = sat_add(exp_bin[{2'd1, 3'd5}]);
    hit_pend[3] = 1; hit_code[3] = 3'd0; exp_bin[{2'd3, 3'd0}] = sat_add(exp_bin[{2'd3, 3'd0}]);
    pulse(start_i);
    while (fd_count == fd0) @(negedge clk);
    stop_to_idle();
    check(fd_count == fd0 + 1, "R7 one frame", fd_count - fd0, 1);
    compare_mem("R3 bin per channel and code");
  endtask

  task automatic t_saturate();
    pulse(start_i);
    for (int k = 0; k < 9; k++) begin
      int fd0 = fd_count;
      hit_pend[3] = 1; hit_code[3] = 3'd7;
      exp_bin[{2'd3, 3'd7}] = sat_add(exp_bin[{2'd3, 3'd7}]);
      while (fd_count == fd0) @(negedge clk);
    end
    stop_to_idle();
    check(int'(mem[DEPTH - 1]) == FULL, "R6 saturated bin", int'(mem[DEPTH - 1]), FULL);
    compare_mem("R6 other bins untouched");
  endtask

  task automatic t_stop_resume();
    int exp_ch;
    pulse(start_i);
    while (!(sw_en_o != '0 && ch_addr_o == CHW'(1))) @(negedge clk);
    stop_to_idle();
    exp_ch = 2;
    check(int'(ch_addr_o) == exp_ch, "R10 index after stop", int'(ch_addr_o), exp_ch);
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (sw_en_o != '0) check(0, "R10 idle after stop", int'(sw_en_o), 0);
    end
    check(sw_en_o == '0, "R10 switches open", int'(sw_en_o), 0);
    pulse(start_i);
    while (sw_en_o == '0) @(negedge clk);
    check(int'(ch_addr_o) == exp_ch, "R10 resume channel", int'(ch_addr_o), exp_ch);
    stop_to_idle();
  endtask

  initial begin
    t_reset();
    t_clear();
    t_hits();
    t_saturate();
    t_stop_resume();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule